// File: doc/BRIEF.md
# Three-Channel Match Timer with Cross-Domain Count Snapshot

This block provides a set of up-counters that run in their own timer clock, each compared every tick against three programmable match values. A simple word-addressed register bus in the bus clock programs the counters, enables and masks match interrupts, and clears status with write-one-to-clear semantics. Every counter can restart after its first match value (periodic) or roll over at its full width (free-running). In free-running mode it serves as a monotonic time base for software.

The count itself is never sampled directly across the clock boundary. Software writes a request to a channel's snapshot word. The timer domain captures the count and returns an acknowledge. The bus domain then loads a stable copy, which a later read returns. Match events cross into the bus domain as toggles, so no tick is lost while the timer clock is at most half the bus clock. Configuration values other than the enable bits are treated as quasi-static: software changes them only while the channel is stopped.

Top module: `mtm_top`

## Requirements
- R1: After reset every mapped register reads 0 and `irq_o` is all zeros.
- R2: Word 0 holds one run bit per counter, with bit n controlling counter n. Writing 0x3 runs counters 0 and 1. Writing 0x2 stops counter 0 and keeps counter 1 running. A stopped counter holds the value 0, so its next run starts from zero, and its match events stop.
- R3: Mode bit 0 (free-running): the counter advances by one per timer tick and rolls from all ones to 0. Two snapshots requested D timer ticks apart differ by exactly D.
- R4: Mode bit 1 (periodic): the counter returns to 0 on the tick after it equals match value 0. A match value of N-1 therefore gives a match-0 event every N ticks, for N from 16 to 0xFFFFFFFE.
- R5: Each channel has three comparators. Status bit m is set when the count equals match value m, and it stays set until software clears it.
- R6: Writing 1 to status bit m clears that bit, writing 0 leaves it, and 0x7 clears all three. A clear in the same cycle as a set wins.
- R7: `irq_o[n]` is high exactly when channel n has a status bit whose interrupt-enable bit (bit m of the enable word) is also 1.
- R8: A write to a channel's snapshot word requests a capture. The captured count is readable there within 12 bus cycles, provided the timer clock is at most half the bus clock. It stays unchanged until the next request.
- R9: Map, in 32-bit words (`addr_i[ADDR_W-1:2]`, with `addr_i[1:0]` zero): word 0 holds the run bits. Channel n starts at word 8(n+1) and uses these offsets: +0..+2 match m, +3 status, +4 interrupt enable, +5 mode, +6 snapshot. Every other word reads 0 and ignores writes. Read data appears on `rdata_o` in the cycle after the read strobe; otherwise `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| tclk_i | input | 1 | Timer tick clock, at most half the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_CNT | Per-channel interrupt, OR of enabled status bits |

## Verification
Register reads return on the cycle after the strobe. Status clears and interrupt-enable changes show on `irq_o` at the next bus-clock sample. The bench samples at exactly those points. In periodic mode a match-0 event reaches status every 2N bus cycles with a 2:1 clock ratio, independent of synchronizer depth. The bench therefore predicts `irq_o` on every cycle of four consecutive periods once the first rise is seen. Synchronizer latency is absorbed in two places: snapshots are read 12 cycles after the request, and the restart-from-zero check accepts the first match within a window of 30 to 48 cycles after re-enable. Snapshot arithmetic is kept exact by issuing both requests at a fixed phase, 100 bus cycles apart.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
  localparam int unsigned OFF_W = 3;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd3;
  localparam logic [OFF_W-1:0] OFF_IE   = 3'd4;
  localparam logic [OFF_W-1:0] OFF_MODE = 3'd5;
  localparam logic [OFF_W-1:0] OFF_SNAP = 3'd6;
endpackage

// File: rtl/mtm_sync.sv
module mtm_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/mtm_tcore.sv
module mtm_tcore #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_MATCH = 3
) (
  input  logic                                tclk_i,
  input  logic                                rst_ni,
  input  logic                                en_i,
  input  logic                                periodic_i,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0]     match_i,
  input  logic                                req_tgl_i,
  output logic [NUM_MATCH-1:0]                hit_tgl_o,
  output logic [CNT_W-1:0]                    snap_o,
  output logic                                ack_tgl_o
);
  logic en_t, req_s, req_d;
  logic [CNT_W-1:0] cnt_q;
  logic [NUM_MATCH-1:0] hit;

  mtm_sync #(.W(1)) u_en_sync  (.clk_i(tclk_i), .rst_ni(rst_ni), .d_i(en_i),      .q_o(en_t));
  mtm_sync #(.W(1)) u_req_sync (.clk_i(tclk_i), .rst_ni(rst_ni), .d_i(req_tgl_i), .q_o(req_s));

  for (genvar m = 0; m < NUM_MATCH; m++) begin : g_cmp
    assign hit[m] = en_t && (cnt_q == match_i[m]);
  end

  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      hit_tgl_o <= '0;
      req_d     <= 1'b0;
      snap_o    <= '0;
      ack_tgl_o <= 1'b0;
    end else begin
      if (!en_t)                            cnt_q <= '0;
      else if (periodic_i && hit[0])        cnt_q <= '0;
      else                                  cnt_q <= cnt_q + CNT_W'(1);
      hit_tgl_o <= hit_tgl_o ^ hit;
      req_d     <= req_s;
      if (req_s ^ req_d) begin
        snap_o    <= cnt_q;
        ack_tgl_o <= ~ack_tgl_o;
      end
    end
  end
endmodule

// File: rtl/mtm_chan.sv
module mtm_chan import mtm_pkg::*; #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_MATCH = 3,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              tclk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
  logic [NUM_MATCH-1:0] stat_q, ie_q, hit_tgl, hit_s, hit_d, hit_set;
  logic mode_q, req_tgl_q, ack_tgl, ack_s, ack_d, wr_stat;
  logic [CNT_W-1:0] snap_t, snap_q;

  mtm_tcore #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_core (
    .tclk_i, .rst_ni, .en_i, .periodic_i(mode_q), .match_i(match_q),
    .req_tgl_i(req_tgl_q), .hit_tgl_o(hit_tgl), .snap_o(snap_t), .ack_tgl_o(ack_tgl)
  );

  mtm_sync #(.W(NUM_MATCH)) u_hit_sync (.clk_i, .rst_ni, .d_i(hit_tgl), .q_o(hit_s));
  mtm_sync #(.W(1))         u_ack_sync (.clk_i, .rst_ni, .d_i(ack_tgl), .q_o(ack_s));

  assign hit_set = hit_s ^ hit_d;
  assign wr_stat = wr_i && (off_i == OFF_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_d     <= '0;
      ack_d     <= 1'b0;
      match_q   <= '0;
      ie_q      <= '0;
      mode_q    <= 1'b0;
      req_tgl_q <= 1'b0;
      snap_q    <= '0;
    end else begin
      hit_d <= hit_s;
      ack_d <= ack_s;
      if (wr_i) begin
        for (int m = 0; m < NUM_MATCH; m++)
          if (off_i == OFF_W'(m)) match_q[m] <= wdata_i[CNT_W-1:0];
        if (off_i == OFF_IE)   ie_q      <= wdata_i[NUM_MATCH-1:0];
        if (off_i == OFF_MODE) mode_q    <= wdata_i[0];
        if (off_i == OFF_SNAP) req_tgl_q <= ~req_tgl_q;
      end
      if (ack_s ^ ack_d) snap_q <= snap_t;
    end
  end

  // clear beats a coincident set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else begin
      for (int m = 0; m < NUM_MATCH; m++) begin
        if (wr_stat && wdata_i[m]) stat_q[m] <= 1'b0;
        else if (hit_set[m])       stat_q[m] <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int m = 0; m < NUM_MATCH; m++)
      if (off_i == OFF_W'(m)) rdata_o = DATA_W'(match_q[m]);
    case (off_i)
      OFF_STAT: rdata_o = DATA_W'(stat_q);
      OFF_IE:   rdata_o = DATA_W'(ie_q);
      OFF_MODE: rdata_o = DATA_W'(mode_q);
      OFF_SNAP: rdata_o = DATA_W'(snap_q);
      default:  ;
    endcase
  end

  assign irq_o = |(stat_q & ie_q);
endmodule

// File: rtl/mtm_top.sv
module mtm_top import mtm_pkg::*; #(
  parameter int unsigned NUM_CNT   = 3,
  parameter int unsigned NUM_MATCH = 3,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic               clk_i,
  input  logic               tclk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_CNT-1:0] irq_o
);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned CH_W   = WORD_W - OFF_W;

  logic [WORD_W-1:0] word;
  logic [CH_W-1:0]   ch_idx;
  logic [OFF_W-1:0]  off;
  logic              aligned, wr, en_hit;
  logic [NUM_CNT-1:0] en_q, ch_hit;
  logic [NUM_CNT-1:0][DATA_W-1:0] ch_rdata;
  logic [DATA_W-1:0] rd_mux;

  assign word    = addr_i[ADDR_W-1:2];
  assign ch_idx  = word[WORD_W-1:OFF_W];
  assign off     = word[OFF_W-1:0];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = sel_i && we_i && aligned;
  assign en_hit  = aligned && (word == '0);

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_ch
    assign ch_hit[n] = aligned && (ch_idx == CH_W'(n + 1));
    mtm_chan #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .DATA_W(DATA_W)) u_chan (
      .clk_i, .tclk_i, .rst_ni,
      .en_i(en_q[n]), .wr_i(wr && ch_hit[n]), .off_i(off), .wdata_i(wdata_i),
      .rdata_o(ch_rdata[n]), .irq_o(irq_o[n])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (en_hit) rd_mux = DATA_W'(en_q);
    for (int n = 0; n < NUM_CNT; n++)
      if (ch_hit[n]) rd_mux = ch_rdata[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      rdata_o <= '0;
    end else begin
      if (wr && en_hit) en_q <= wdata_i[NUM_CNT-1:0];
      rdata_o <= (sel_i && !we_i) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/mtm_chk.sv
module mtm_bus_chk import mtm_pkg::*; #(
  parameter int unsigned NUM_MATCH = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_i,
  input logic [OFF_W-1:0]     off_i,
  input logic [NUM_MATCH-1:0] wbits_i,
  input logic [NUM_MATCH-1:0] stat_q,
  input logic [NUM_MATCH-1:0] ie_q,
  input logic                 irq_o
);
  for (genvar m = 0; m < NUM_MATCH; m++) begin : g_m
    a_r6_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && off_i == OFF_STAT && wbits_i[m]) |=> !stat_q[m]);
    a_r5_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[m] && !(wr_i && off_i == OFF_STAT && wbits_i[m])) |=> stat_q[m]);
  end
  a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == '0) |-> !irq_o);
endmodule

module mtm_core_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             tclk_i,
  input logic             rst_ni,
  input logic             en_t,
  input logic             periodic_i,
  input logic [CNT_W-1:0] match0_i,
  input logic [CNT_W-1:0] cnt_q
);
  a_r2_stop_clears: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    !en_t |=> (cnt_q == '0));
  a_r4_periodic_restart: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    (en_t && periodic_i && cnt_q == match0_i) |=> (cnt_q == '0));
  a_r3_free_wrap: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    (en_t && !periodic_i && cnt_q == '1) |=> (cnt_q == '0));
  a_r3_step_one: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    (en_t && !periodic_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0));
endmodule

bind mtm_chan mtm_bus_chk #(.NUM_MATCH(NUM_MATCH)) u_bus_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .off_i(off_i),
  .wbits_i(wdata_i[NUM_MATCH-1:0]), .stat_q(stat_q), .ie_q(ie_q), .irq_o(irq_o)
);

bind mtm_tcore mtm_core_chk #(.CNT_W(CNT_W)) u_core_chk (
  .tclk_i(tclk_i), .rst_ni(rst_ni), .en_t(en_t), .periodic_i(periodic_i),
  .match0_i(match_i[0]), .cnt_q(cnt_q)
);

// File: tb/sim_mtm_top.sv
module sim_mtm_top;
  localparam int CLK_P = 10;

  logic clk, tclk, rst_n, sel, we;
  logic [7:0] addr;
  logic [31:0] wdata, rdata;
  logic [2:0] irq;
  int n_chk, n_fail, cyc;
  logic [31:0] rv, s1, s2;

  mtm_top u0 (
    .clk_i(clk), .tclk_i(tclk), .rst_ni(rst_n), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  initial begin clk = 0; forever #(CLK_P/2) clk = ~clk; end
  initial begin tclk = 0; #2; forever #(CLK_P) tclk = ~tclk; end

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic bwr(input int w, input logic [31:0] d);
    sel = 1; we = 1; addr = 8'(w << 2); wdata = d;
    tick();
    sel = 0; we = 0;
  endtask

  task automatic brd(input int w, output logic [31:0] d);
    sel = 1; we = 0; addr = 8'(w << 2);
    tick();
    sel = 0;
    d = rdata;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int tw, c0;
    n_chk = 0; n_fail = 0; cyc = 0;
    sel = 0; we = 0; addr = '0; wdata = '0; rst_n = 0;
    repeat (4) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    brd(0, rv);  chk("R1 run bits", rv, 0);
    brd(11, rv); chk("R1 status", rv, 0);
    brd(8, rv);  chk("R1 match0", rv, 0);

    // R9 unmapped words
    bwr(7, 32'hFFFF);
    brd(7, rv);  chk("R9 word7", rv, 0);
    brd(15, rv); chk("R9 ch0 off7", rv, 0);
    brd(32, rv); chk("R9 no ch3", rv, 0);

    // ch0 periodic N=16, ch1 free-running
    bwr(8, 15); bwr(9, 5); bwr(10, 100); bwr(12, 1); bwr(13, 1);
    brd(9, rv);  chk("R9 match1 readback", rv, 5);
    brd(13, rv); chk("R9 mode readback", rv, 1);
    bwr(16, 60000); bwr(17, 30); bwr(18, 60000); bwr(20, 0); bwr(21, 0);

    bwr(0, 3);
    brd(0, rv); chk("R2 run 0x3", rv, 3);

    for (int i = 0; i < 200 && !irq[0]; i++) tick();
    chk("R4 first match0 irq", 32'(irq[0]), 1);

    // per-cycle model of irq over four periods of 32 bus cycles
    for (int p = 0; p < 4; p++) begin
      brd(11, rv);
      chk("R5 status both", rv, 3);
      chk("R7 irq held", 32'(irq[0]), 1);
      bwr(11, 7);
      chk("R6 clear drops irq", 32'(irq[0]), 0);
      for (int k = 3; k < 32; k++) begin
        tick();
        chk("R4 quiet in period", 32'(irq[0]), 0);
        chk("R7 ch1 masked", 32'(irq[1]), 0);
      end
      tick();
      chk("R4 period N ticks", 32'(irq[0]), 1);
    end

    // R6 partial clear
    bwr(11, 2);
    brd(11, rv); chk("R6 partial clear", rv, 1);
    bwr(11, 7);

    // ch1 free-running compare 1 with mask
    brd(19, rv); chk("R5 ch1 match1 only", rv, 2);
    chk("R7 ch1 masked", 32'(irq[1]), 0);
    bwr(20, 2);
    chk("R7 ch1 unmasked", 32'(irq[1]), 1);
    bwr(19, 2);
    chk("R6 ch1 cleared irq", 32'(irq[1]), 0);
    brd(19, rv); chk("R6 ch1 status", rv, 0);

    // R8 / R3 snapshots 100 bus cycles (50 ticks) apart
    tw = cyc;
    bwr(22, 0);
    wait_to(tw + 12);
    brd(22, s1);
    chk("R8 snapshot nonzero", 32'(s1 != 0), 1);
    wait_to(tw + 40);
    brd(22, rv); chk("R8 snapshot stable", rv, s1);
    wait_to(tw + 100);
    bwr(22, 0);
    wait_to(tw + 112);
    brd(22, s2);
    chk("R3 snapshot delta", s2 - s1, 50);

    // R2 stop counter 0
    bwr(0, 2);
    brd(0, rv); chk("R2 run 0x2", rv, 2);
    repeat (10) tick();
    tw = cyc;
    bwr(14, 0);
    wait_to(tw + 12);
    brd(14, rv); chk("R2 stopped count zero", rv, 0);
    bwr(11, 7);
    repeat (80) tick();
    chk("R2 no irq when stopped", 32'(irq[0]), 0);
    brd(11, rv); chk("R2 no status when stopped", rv, 0);
    tw = cyc;
    bwr(22, 0);
    wait_to(tw + 12);
    brd(22, rv); chk("R2 counter1 still runs", 32'(rv > s2), 1);

    // R2 restart from zero: first match after about 16 ticks plus sync
    bwr(0, 3);
    c0 = cyc;
    for (int i = 0; i < 100 && !irq[0]; i++) tick();
    if (!(cyc - c0 >= 30 && cyc - c0 <= 48)) begin
      n_chk++; n_fail++;
      $display("FAIL R2 restart latency: actual %0d expected 30..48", cyc - c0);
    end else n_chk++;

    chk("R7 ch2 idle", 32'(irq[2]), 0);
    summary();
    $finish;
  end
endmodule